// File: doc/BRIEF.md
# Serial Flash SPI Target Front End

This block is the serial-side front end of a small flash-style SPI target. It runs from a fast system clock. It oversamples the serial clock, chip select, pause, write-protect and data-in pins, and it finds serial clock edges internally.

Once the target is selected, the block shifts in an 8-bit instruction and any 24-bit address. It then either updates its status register or shifts read data out. Read data can leave on one pin, or on two pins with two bits per serial clock. Each output pin has its own enable, so the pins can sit on a shared bus.

The block holds a small status register. It also holds a fixed data buffer of `BUF_BYTES` bytes, whose contents are computed from the byte index. Serial clock frequency must be at most a quarter of the system clock.

Top module: `sflash_spi_front`

## Requirements
- R1: While chip select (`csn_i`) is high, both output enables are low. Raising chip select at any point stops driving within a few system clocks.
- R2: After reset, no instruction is accepted until `csn_i` has been seen high and then low. With chip select held low straight out of reset, a status read leaves both enables low.
- R3: The instruction is the first 8 bits after selection. It is sampled on `io0_i` at rising serial clock edges, MSB first. An opcode outside the supported set (06h, 05h, 01h, 03h, 3Bh) is ignored: nothing is driven and no state changes. For example 60h does not set the write-enable flag.
- R4: Opcode 05h returns the status byte on `io1_o`, MSB first, repeated for as long as clocks continue. Each bit changes only after a falling serial clock edge. Status layout: bit 7 protect-lock, bit 6 reads 0, bit 5 top/bottom, bits 4..2 block-protect, bit 1 write-enable flag, bit 0 busy (always 0). Reset value is 00h.
- R5: Opcode 06h sets the write-enable flag (status bit 1).
- R6: Opcode 01h followed by 8 data bits writes status bits 7, 5, 4, 3 and 2 only if the write-enable flag is set. Completing the 8 data bits clears the flag. Without the flag the write has no effect.
- R7: While `wpn_i` is low and status bit 7 is set, a status write changes no bit. It still clears the write-enable flag.
- R8: Opcode 03h takes a 24-bit address, MSB first. It then returns bytes MSB first on `io1_o`. The first byte is at the address and each later byte is at the next address. The address wraps within the buffer, and the byte at index i = address mod `BUF_BYTES` equals (29*i + 7) mod 256.
- R9: Opcode 3Bh takes a 24-bit address, then 8 dummy clocks, then returns the same bytes as R8 two bits per clock. `io1_o` carries bits 7, 5, 3, 1 and `io0_o` carries bits 6, 4, 2, 0, with both enables high.
- R10: While selected, `holdn_i` low drops both enables and ignores serial clock and data transitions. Raising it resumes at the exact bit where the transfer paused.
- R11: Deselecting mid-transfer aborts it. The next selection starts a new instruction, and a partly shifted status write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock |
| csn_i | input | 1 | Chip select, active low |
| holdn_i | input | 1 | Pause, active low |
| wpn_i | input | 1 | Write protect, active low |
| io0_i | input | 1 | Serial data in (I/O pin 0 input) |
| io0_o | output | 1 | I/O pin 0 output value (dual reads) |
| io0_oe | output | 1 | I/O pin 0 output enable |
| io1_o | output | 1 | I/O pin 1 output value |
| io1_oe | output | 1 | I/O pin 1 output enable |

## Verification
Every pin passes through two synchronizer flops and one edge-detect register. An output bit therefore settles about four system clocks after the serial falling edge that launches it. Status and enable changes take the same time after the edge or pin change that causes them. The bench holds each serial clock phase for eight system clocks and samples outputs at a falling system clock edge just before it raises the serial clock, well after every result is due. Status writes are checked through a later status read, and data reads are swept over many start addresses with expected bytes computed from the index formula.

// File: rtl/sflash_spi_front.sv
`timescale 1ns/1ps
module sflash_spi_front #(
  parameter int BUF_BYTES   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BITS   = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic holdn_i,
  input  logic wpn_i,
  input  logic io0_i,
  output logic io0_o,
  output logic io0_oe,
  output logic io1_o,
  output logic io1_oe
);

  localparam int IW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;
  localparam logic [4:0] ADDR_LAST = 5'(ADDR_BITS - 1);
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_DREAD = 8'h3B;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_DUMMY, S_WSR, S_OUT, S_SKIP} st_t;

  function automatic logic [7:0] rom_byte(input logic [IW-1:0] i);
    return 8'(32'(i) * 32'd29 + 32'd7);
  endfunction

  logic [SYNC_STAGES-1:0] sck_p, cs_p, hold_p, wp_p, di_p;
  logic sck_d, cs_d;
  logic sck_s, cs_s, hold_s, wp_s, di_s;

  st_t st;
  logic                 sel;
  logic [4:0]           cnt;
  logic [6:0]           sh;
  logic [7:0]           op;
  logic [ADDR_BITS-1:0] addr;
  logic [7:0]           osr;
  logic                 io0_q, io1_q;
  logic                 wel, srp, tb;
  logic [2:0]           bp;

  assign sck_s  = sck_p[SYNC_STAGES-1];
  assign cs_s   = cs_p[SYNC_STAGES-1];
  assign hold_s = hold_p[SYNC_STAGES-1];
  assign wp_s   = wp_p[SYNC_STAGES-1];
  assign di_s   = di_p[SYNC_STAGES-1];

  wire rise    = sck_s & ~sck_d;
  wire fall    = ~sck_s & sck_d;
  wire cs_fall = cs_d & ~cs_s;
  wire held    = sel & ~hold_s;
  wire go      = sel & ~held & ~cs_s;
  wire dual    = (op == OP_DREAD);

  wire [7:0]           nxt_in   = {sh, di_s};
  wire [ADDR_BITS-1:0] addr_in  = {addr[ADDR_BITS-2:0], di_s};
  wire [ADDR_BITS-1:0] addr_inc = addr + 1'b1;
  wire [7:0]           status_w = {srp, 1'b0, tb, bp, wel, 1'b0};
  wire                 last_slot = dual ? (cnt == 5'd3) : (cnt == 5'd7);
  wire                 wsr_fire  = go & rise & (st == S_WSR) & (cnt == 5'd7);
  wire                 wr_lock   = srp & ~wp_s;

  assign io1_o  = io1_q;
  assign io0_o  = io0_q;
  assign io1_oe = go & (st == S_OUT);
  assign io0_oe = go & (st == S_OUT) & dual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '0;
      hold_p <= '1;
      wp_p   <= '1;
      di_p   <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b0;
      sel    <= 1'b0;
      st     <= S_CMD;
      cnt    <= '0;
      sh     <= '0;
      op     <= '0;
      addr   <= '0;
      osr    <= '0;
      io0_q  <= 1'b0;
      io1_q  <= 1'b0;
      wel    <= 1'b0;
      srp    <= 1'b0;
      tb     <= 1'b0;
      bp     <= '0;
    end else begin
      sck_p  <= {sck_p[SYNC_STAGES-2:0], sck_i};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], csn_i};
      hold_p <= {hold_p[SYNC_STAGES-2:0], holdn_i};
      wp_p   <= {wp_p[SYNC_STAGES-2:0], wpn_i};
      di_p   <= {di_p[SYNC_STAGES-2:0], io0_i};
      sck_d  <= sck_s;
      cs_d   <= cs_s;

      if (cs_s) begin
        sel <= 1'b0;
        st  <= S_CMD;
        cnt <= '0;
      end else begin
        if (cs_fall) sel <= 1'b1;

        if (go && rise) begin
          unique case (st)
            S_CMD: begin
              sh <= nxt_in[6:0];
              if (cnt == 5'd7) begin
                cnt <= '0;
                op  <= nxt_in;
                unique case (nxt_in)
                  OP_WREN: begin
                    wel <= 1'b1;
                    st  <= S_SKIP;
                  end
                  OP_RDSR: begin
                    osr <= status_w;
                    st  <= S_OUT;
                  end
                  OP_WRSR:           st <= S_WSR;
                  OP_READ, OP_DREAD: st <= S_ADDR;
                  default:           st <= S_SKIP;
                endcase
              end else begin
                cnt <= cnt + 5'd1;
              end
            end
            S_ADDR: begin
              addr <= addr_in;
              if (cnt == ADDR_LAST) begin
                cnt <= '0;
                osr <= rom_byte(addr_in[IW-1:0]);
                st  <= dual ? S_DUMMY : S_OUT;
              end else begin
                cnt <= cnt + 5'd1;
              end
            end
            S_DUMMY: begin
              if (cnt == 5'd7) begin
                cnt <= '0;
                st  <= S_OUT;
              end else begin
                cnt <= cnt + 5'd1;
              end
            end
            S_WSR: begin
              sh <= nxt_in[6:0];
              if (cnt == 5'd7) begin
                cnt <= '0;
                st  <= S_SKIP;
                if (wel) begin
                  wel <= 1'b0;
                  if (!wr_lock) begin
                    srp <= nxt_in[7];
                    tb  <= nxt_in[5];
                    bp  <= nxt_in[4:2];
                  end
                end
              end else begin
                cnt <= cnt + 5'd1;
              end
            end
            default: ;
          endcase
        end

        if (go && fall && st == S_OUT) begin
          io1_q <= osr[7];
          if (dual) io0_q <= osr[6];
          if (last_slot) begin
            cnt <= '0;
            if (op == OP_RDSR) begin
              osr <= status_w;
            end else begin
              osr  <= rom_byte(addr_inc[IW-1:0]);
              addr <= addr_inc;
            end
          end else begin
            cnt <= cnt + 5'd1;
            osr <= dual ? {osr[5:0], 2'b00} : {osr[6:0], 1'b0};
          end
        end
      end
    end
  end

  AST_IDLE_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (st == S_CMD && cnt == 5'd0)); // R2
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> (st == S_CMD && cnt == 5'd0 && !io1_oe)); // R11
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_s) |=> ($stable(cnt) && $stable(st) && $stable(osr))); // R10
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OUT && !(go && fall)) |=> $stable(io1_o)); // R4
  AST_WREN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (go && rise && st == S_CMD && cnt == 5'd7 && nxt_in == OP_WREN) |=> wel); // R5
  AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wsr_fire |=> !wel); // R6
  AST_NOWEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wsr_fire && !wel) |=> ($stable(srp) && $stable(tb) && $stable(bp))); // R6
  AST_WP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wsr_fire && srp && !wp_s) |=> ($stable(srp) && $stable(tb) && $stable(bp))); // R7

endmodule

// File: tb/sflash_spi_front_bench.sv
`timescale 1ns/1ps
module sflash_spi_front_bench;
  localparam int H = 8;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b0, holdn = 1'b1, wpn = 1'b1, di = 1'b0;
  logic io0_o, io0_oe, io1_o, io1_oe;
  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] exp_sr = 8'h00;

  always #2.5 clk = ~clk;

  sflash_spi_front #(.BUF_BYTES(NB)) u_sflash_spi_front (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .holdn_i(holdn),
    .wpn_i(wpn), .io0_i(di), .io0_o(io0_o), .io0_oe(io0_oe),
    .io1_o(io1_o), .io1_oe(io1_oe));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d cycles expected<190000", cyc);
      summary();
    end
  end

  function automatic logic [7:0] rom(input int a);
    return 8'(((a % NB) * 29 + 7) % 256);
  endfunction

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic select(); csn = 1'b0; idle(H); endtask
  task automatic deselect(); csn = 1'b1; di = 1'b0; idle(2 * H); endtask
  task automatic put_bit(input bit b); di = b; idle(H); sck = 1'b1; idle(H); sck = 1'b0; endtask
  task automatic put_byte(input logic [7:0] v); for (int i = 7; i >= 0; i--) put_bit(v[i]); endtask

  task automatic pause_here(input string req);
    holdn = 1'b0; idle(H);
    check(!io1_oe && !io0_oe, req, {io1_oe, io0_oe}, 0);
    for (int k = 0; k < 3; k++) begin di = ~di; idle(H); sck = 1'b1; idle(H); sck = 1'b0; end
    holdn = 1'b1; idle(H);
  endtask

  task automatic put_addr(input logic [23:0] a, input int hold_at);
    for (int i = 23; i >= 0; i--) begin
      if (i == hold_at) pause_here("R10 hold during address");
      put_bit(a[i]);
    end
  endtask

  task automatic get_std(output logic [7:0] v, output int oe_bad, input int hold_at);
    v = '0; oe_bad = 0;
    for (int i = 7; i >= 0; i--) begin
      if (i == hold_at) pause_here("R10 hold during read");
      idle(H);
      v[i] = io1_o;
      if (!io1_oe || io0_oe) oe_bad++;
      sck = 1'b1; idle(H); sck = 1'b0;
    end
  endtask

  task automatic get_dual(output logic [7:0] v, output int oe_bad);
    v = '0; oe_bad = 0;
    for (int i = 3; i >= 0; i--) begin
      idle(H);
      v[2*i+1] = io1_o; v[2*i] = io0_o;
      if (!io1_oe || !io0_oe) oe_bad++;
      sck = 1'b1; idle(H); sck = 1'b0;
    end
  endtask

  task automatic rd_status(output logic [7:0] v);
    int bad;
    select(); put_byte(8'h05); get_std(v, bad, -1); deselect();
    check(bad == 0, "R4 status read enables", bad, 0);
  endtask

  task automatic cmd(input logic [7:0] op); select(); put_byte(op); deselect(); endtask
  task automatic wr_status(input logic [7:0] d); select(); put_byte(8'h01); put_byte(d); deselect(); endtask

  initial begin
    logic [7:0] v;
    int bad;
    idle(4); rst_n = 1'b1; idle(4);
    check(!io1_oe && !io0_oe, "R1 reset enables", {io1_oe, io0_oe}, 0);

    // R2: chip select low since reset, no fresh falling edge
    put_byte(8'h05); get_std(v, bad, -1);
    check(bad == 8, "R2 no command before fresh select", bad, 8);
    deselect();
    check(!io1_oe && !io0_oe, "R1 deselected enables", {io1_oe, io0_oe}, 0);

    // R4: reset status, repeated twice in one selection
    select(); put_byte(8'h05);
    get_std(v, bad, -1); check(v == 8'h00 && bad == 0, "R4 status first", v, 0);
    get_std(v, bad, -1); check(v == 8'h00 && bad == 0, "R4 status repeat", v, 0);
    deselect();

    // R3: unknown opcode and bit-reversed write-enable ignored
    select(); put_byte(8'hAB); get_std(v, bad, -1); deselect();
    check(bad == 8, "R3 unknown opcode not driven", bad, 8);
    cmd(8'h60); rd_status(v); check(v == 8'h00, "R3 60h ignored", v, 0);

    // R5, R6
    cmd(8'h06); rd_status(v); check(v == 8'h02, "R5 write enable", v, 8'h02);
    wr_status(8'hDF); exp_sr = 8'hDF & 8'hBC;
    rd_status(v); check(v == exp_sr, "R6 status write", v, exp_sr);
    wr_status(8'h00); rd_status(v); check(v == exp_sr, "R6 write without enable", v, exp_sr);

    // R7: protect lock with wpn low
    wpn = 1'b0;
    cmd(8'h06); wr_status(8'h00); rd_status(v); check(v == exp_sr, "R7 write blocked", v, exp_sr);
    wpn = 1'b1;
    cmd(8'h06); wr_status(8'h14); exp_sr = 8'h14;
    rd_status(v); check(v == exp_sr, "R7 write allowed when wpn high", v, exp_sr);

    // R11: aborted status write, then aborted instruction
    cmd(8'h06);
    select(); put_byte(8'h01); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); deselect();
    rd_status(v); check(v == (exp_sr | 8'h02), "R11 aborted status write", v, exp_sr | 8'h02);
    wr_status(8'h14);
    select(); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); deselect();
    rd_status(v); check(v == exp_sr, "R11 fresh instruction after abort", v, exp_sr);

    // R8: single-pin reads over a sweep of start addresses with wrap
    for (int a = 0; a < NB; a++) begin
      int base;
      base = 24'h012340 + a * 7;
      select(); put_byte(8'h03); put_addr(24'(base), -1);
      for (int k = 0; k < 3; k++) begin
        get_std(v, bad, -1);
        check(v == rom(base + k) && bad == 0, "R8 read data byte", v, rom(base + k));
      end
      deselect();
    end

    // R11: abort mid-read, then a clean read
    select(); put_byte(8'h03); put_addr(24'h000005, -1); get_std(v, bad, -1); put_bit(1'b0); deselect();
    select(); put_byte(8'h03); put_addr(24'h00000A, -1); get_std(v, bad, -1); deselect();
    check(v == rom(10), "R11 read after aborted read", v, rom(10));

    // R9: dual reads
    for (int a = 0; a < 8; a++) begin
      int base;
      base = 24'hA00000 + a * 5 + 9;
      select(); put_byte(8'h3B); put_addr(24'(base), -1);
      for (int k = 0; k < 8; k++) put_bit(k[0]);
      for (int k = 0; k < 4; k++) begin
        get_dual(v, bad);
        check(v == rom(base + k) && bad == 0, "R9 dual read byte", v, rom(base + k));
      end
      deselect();
    end

    // R10: hold mid-address and mid-byte, resume at the same bit
    select(); put_byte(8'h03); put_addr(24'h000003, 9);
    get_std(v, bad, 4); check(v == rom(3) && bad == 0, "R10 resume first byte", v, rom(3));
    get_std(v, bad, 0); check(v == rom(4) && bad == 0, "R10 resume second byte", v, rom(4));
    deselect();

    summary();
  end
endmodule